// File: doc/BRIEF.md
# Single-Wire Smart-Card Serial Transceiver

This block is a half-duplex asynchronous transceiver for a link where the transmit and receive pins share one wire that is pulled up externally. It sends and receives eleven-bit character frames that carry even parity. The block only ever pulls the wire low. A released output reads as high through the pull-up. Bit timing comes from an oversampling enable that pulses `OVS` times per bit.

When the enable for error signaling is set and a received character fails its parity check, the block holds the shared wire low. This tells the far end that the character must be repeated. The low is released only when the host reads the receive buffer, and the same read clears the parity flag.

On the transmit side, a one-cycle interrupt marks the end of the stop bit. At that moment the host can read the live wire level to find out whether the far end is pulling the line low to reject the character. While the transmitter is busy, the receiver ignores the echo of its own frame.

Top module: `card_uart`

## Requirements
- R1: After reset the wire is released (`line_drive` = 0) and `tx_busy`, `rx_full`, `parity_err`, `overrun`, `tx_done_irq` and `rx_irq` are all 0.
- R2: A write to an idle transmitter sends a frame on `line_drive`, with 1 meaning the wire is pulled low. The frame is a start bit of 0, then data bits 0 to 7 in that order, then a bit that makes the count of ones in data plus parity even, then a stop bit of 1. Each bit lasts `OVS` sample enables.
- R3: `tx_done_irq` is high for exactly one cycle, on the clock edge that ends the stop bit. That edge comes 11×`OVS` sample enables after the edge that accepted the write. `tx_busy` falls on the same edge.
- R4: A write while `tx_busy` is 1 is ignored. The frame in progress is unchanged, and no second frame follows it.
- R5: The receiver detects a falling edge on the wire and samples each bit at mid-bit. At the middle of the stop bit it stores the data byte in `rd_data`, sets `rx_full` and pulses `rx_irq`.
- R6: A received parity bit that gives odd parity over data plus parity sets `parity_err` for that stored character. Even parity leaves `parity_err` at 0.
- R7: With `err_sig_en` = 1, a parity error holds `line_drive` at 1 from the middle of the stop bit until the host reads the buffer, for however long that takes.
- R8: With `err_sig_en` = 0, a receive parity error never drives the wire.
- R9: A read (`rd_en` pulse) clears `rx_full`, `parity_err` and `overrun`, and releases the error drive on the same clock edge.
- R10: A character that completes while `rx_full` = 1 (and no read occurs in that cycle) sets `overrun` and leaves `rd_data` unchanged.
- R11: While the transmitter is busy, the receiver does not start a new frame, so the block's own transmission does not appear as received data.
- R12: `line_level` follows the level of the wire through a two-flop synchronizer. A low driven by the far end during the stop bit reads 0 at the cycle `tx_done_irq` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| sample_en | input | 1 | Oversampling enable, `OVS` pulses per bit |
| line_i | input | 1 | Level of the shared wire |
| line_drive | output | 1 | 1 pulls the shared wire low, 0 releases it |
| wr_en | input | 1 | Start transmitting `wr_data` |
| wr_data | input | DATA_W | Byte to transmit |
| rd_en | input | 1 | Host read of the receive buffer |
| rd_data | output | DATA_W | Receive buffer |
| err_sig_en | input | 1 | Enables error signaling on the wire |
| tx_busy | output | 1 | A frame is being transmitted |
| tx_done_irq | output | 1 | One-cycle pulse at the end of the stop bit |
| rx_irq | output | 1 | One-cycle pulse when a character is taken in |
| rx_full | output | 1 | Receive buffer holds an unread character |
| parity_err | output | 1 | Stored character failed the parity check |
| overrun | output | 1 | A character was lost because the buffer was full |
| line_level | output | 1 | Synchronized level of the shared wire |

## Verification
A receive state machine that leaves idle while the transmitter is busy turns the block's own echo into a spurious `rx_full` and `rx_irq` within one frame time. A bit counter that is off by one moves the `tx_done_irq` pulse away from 11×`OVS` enables, and shifts every mid-bit level seen on `line_drive`. An error-drive flag that gets stuck keeps `line_drive` high after a read, which is visible on the next cycle. A buffer that overwrites on overrun shows at once as a changed `rd_data`.

// File: rtl/card_uart_pkg.sv
package card_uart_pkg;

    typedef enum logic [2:0] {
        RX_IDLE,
        RX_START,
        RX_DATA,
        RX_PAR,
        RX_STOP
    } rx_state_e;

    localparam int FRAME_EXTRA = 3;  // start, parity, stop

endpackage

// File: rtl/card_uart_tx.sv
module card_uart_tx
    import card_uart_pkg::*;
#(
    parameter int DATA_W = 8,
    parameter int OVS    = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sample_en,
    input  logic              wr_en,
    input  logic [DATA_W-1:0] wr_data,
    output logic              busy_o,
    output logic              low_o,
    output logic              done_o
);
    localparam int FRAME_W = DATA_W + FRAME_EXTRA;
    localparam int CNT_W   = (OVS > 1) ? $clog2(OVS) : 1;
    localparam int IDX_W   = $clog2(FRAME_W);

    typedef struct packed {
        logic               busy;
        logic [FRAME_W-1:0] shreg;
        logic [CNT_W-1:0]   cnt;
        logic [IDX_W-1:0]   idx;
        logic               done;
    } tx_regs_t;

    tx_regs_t tx_q, tx_d;

    always_comb begin
        tx_d      = tx_q;
        tx_d.done = 1'b0;
        if (!tx_q.busy) begin
            if (wr_en) begin
                tx_d.busy  = 1'b1;
                tx_d.shreg = {1'b1, ^wr_data, wr_data, 1'b0};
                tx_d.cnt   = '0;
                tx_d.idx   = '0;
            end
        end else if (sample_en) begin
            if (tx_q.cnt == CNT_W'(OVS - 1)) begin
                tx_d.cnt   = '0;
                tx_d.shreg = {1'b1, tx_q.shreg[FRAME_W-1:1]};
                if (tx_q.idx == IDX_W'(FRAME_W - 1)) begin
                    tx_d.busy = 1'b0;
                    tx_d.done = 1'b1;
                end else begin
                    tx_d.idx = tx_q.idx + 1'b1;
                end
            end else begin
                tx_d.cnt = tx_q.cnt + 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            tx_q       <= '0;
            tx_q.shreg <= '1;
        end else begin
            tx_q <= tx_d;
        end
    end

    assign busy_o = tx_q.busy;
    assign low_o  = tx_q.busy & ~tx_q.shreg[0];
    assign done_o = tx_q.done;

    AST_DONE_AFTER_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> $past(busy_o)) else $error("done without busy");  // R3

endmodule

// File: rtl/card_uart_rx.sv
module card_uart_rx
    import card_uart_pkg::*;
#(
    parameter int DATA_W = 8,
    parameter int OVS    = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sample_en,
    input  logic              line_i,
    input  logic              block_i,
    output logic              line_s_o,
    output logic              valid_o,
    output logic [DATA_W-1:0] data_o,
    output logic              par_ok_o
);
    localparam int CNT_W = (OVS > 1) ? $clog2(OVS) : 1;
    localparam int IDX_W = (DATA_W > 1) ? $clog2(DATA_W) : 1;
    localparam int HALF  = (OVS / 2 > 0) ? OVS / 2 : 1;

    typedef struct packed {
        logic [1:0]        sync;
        rx_state_e         state;
        logic [CNT_W-1:0]  cnt;
        logic [IDX_W-1:0]  idx;
        logic [DATA_W-1:0] shreg;
        logic              par;
        logic              valid;
        logic [DATA_W-1:0] data;
        logic              par_ok;
    } rx_regs_t;

    rx_regs_t rx_q, rx_d;
    logic     line_s;

    assign line_s = rx_q.sync[1];

    always_comb begin
        rx_d       = rx_q;
        rx_d.valid = 1'b0;
        rx_d.sync  = {rx_q.sync[0], line_i};
        unique case (rx_q.state)
            RX_IDLE: begin
                if (!line_s && !block_i) begin
                    rx_d.state = RX_START;
                    rx_d.cnt   = '0;
                end
            end
            RX_START: begin
                if (sample_en) begin
                    if (rx_q.cnt == CNT_W'(HALF - 1)) begin
                        rx_d.cnt = '0;
                        rx_d.idx = '0;
                        rx_d.state = line_s ? RX_IDLE : RX_DATA;
                    end else begin
                        rx_d.cnt = rx_q.cnt + 1'b1;
                    end
                end
            end
            RX_DATA: begin
                if (sample_en) begin
                    if (rx_q.cnt == CNT_W'(OVS - 1)) begin
                        rx_d.cnt   = '0;
                        rx_d.shreg = {line_s, rx_q.shreg[DATA_W-1:1]};
                        if (rx_q.idx == IDX_W'(DATA_W - 1)) begin
                            rx_d.state = RX_PAR;
                        end else begin
                            rx_d.idx = rx_q.idx + 1'b1;
                        end
                    end else begin
                        rx_d.cnt = rx_q.cnt + 1'b1;
                    end
                end
            end
            RX_PAR: begin
                if (sample_en) begin
                    if (rx_q.cnt == CNT_W'(OVS - 1)) begin
                        rx_d.cnt   = '0;
                        rx_d.par   = line_s;
                        rx_d.state = RX_STOP;
                    end else begin
                        rx_d.cnt = rx_q.cnt + 1'b1;
                    end
                end
            end
            RX_STOP: begin
                if (sample_en) begin
                    if (rx_q.cnt == CNT_W'(OVS - 1)) begin
                        rx_d.cnt    = '0;
                        rx_d.valid  = 1'b1;
                        rx_d.data   = rx_q.shreg;
                        rx_d.par_ok = ((^rx_q.shreg) == rx_q.par);
                        rx_d.state  = RX_IDLE;
                    end else begin
                        rx_d.cnt = rx_q.cnt + 1'b1;
                    end
                end
            end
            default: rx_d.state = RX_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rx_q       <= '0;
            rx_q.sync  <= 2'b11;
            rx_q.state <= RX_IDLE;
        end else begin
            rx_q <= rx_d;
        end
    end

    assign line_s_o = line_s;
    assign valid_o  = rx_q.valid;
    assign data_o   = rx_q.data;
    assign par_ok_o = rx_q.par_ok;

    AST_RX_HOLD_OFF: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_q.state == RX_IDLE && block_i) |=> (rx_q.state == RX_IDLE))
        else $error("receiver left idle while blocked");  // R11

endmodule

// File: rtl/card_uart_hold.sv
module card_uart_hold #(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rx_valid,
    input  logic [DATA_W-1:0] rx_data,
    input  logic              rx_par_ok,
    input  logic              rd_en,
    input  logic              err_en,
    output logic [DATA_W-1:0] data_o,
    output logic              full_o,
    output logic              par_err_o,
    output logic              ovr_o,
    output logic              err_drive_o,
    output logic              irq_o
);
    typedef struct packed {
        logic [DATA_W-1:0] data;
        logic              full;
        logic              par_err;
        logic              ovr;
        logic              err_drive;
        logic              irq;
    } hold_regs_t;

    hold_regs_t h_q, h_d;

    always_comb begin
        h_d     = h_q;
        h_d.irq = 1'b0;
        if (rd_en) begin
            h_d.full      = 1'b0;
            h_d.par_err   = 1'b0;
            h_d.ovr       = 1'b0;
            h_d.err_drive = 1'b0;
        end
        if (rx_valid) begin
            h_d.irq = 1'b1;
            if (h_q.full && !rd_en) begin
                h_d.ovr = 1'b1;
            end else begin
                h_d.data      = rx_data;
                h_d.full      = 1'b1;
                h_d.par_err   = ~rx_par_ok;
                h_d.err_drive = ~rx_par_ok & err_en;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            h_q <= '0;
        end else begin
            h_q <= h_d;
        end
    end

    assign data_o      = h_q.data;
    assign full_o      = h_q.full;
    assign par_err_o   = h_q.par_err;
    assign ovr_o       = h_q.ovr;
    assign err_drive_o = h_q.err_drive;
    assign irq_o       = h_q.irq;

    AST_OVR_KEEPS_DATA: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_valid && full_o && !rd_en) |=> ($stable(data_o) && ovr_o))
        else $error("overrun replaced data");  // R10
    AST_READ_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && !rx_valid) |=> (!full_o && !par_err_o && !err_drive_o && !ovr_o))
        else $error("read did not clear");  // R9

endmodule

// File: rtl/card_uart.sv
module card_uart
    import card_uart_pkg::*;
#(
    parameter int DATA_W = 8,
    parameter int OVS    = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sample_en,
    input  logic              line_i,
    output logic              line_drive,
    input  logic              wr_en,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              rd_en,
    output logic [DATA_W-1:0] rd_data,
    input  logic              err_sig_en,
    output logic              tx_busy,
    output logic              tx_done_irq,
    output logic              rx_irq,
    output logic              rx_full,
    output logic              parity_err,
    output logic              overrun,
    output logic              line_level
);
    logic              tx_low;
    logic              rx_valid;
    logic [DATA_W-1:0] rx_data;
    logic              rx_par_ok;
    logic              err_drive;

    card_uart_tx #(.DATA_W(DATA_W), .OVS(OVS)) u_tx (
        .clk       (clk),
        .rst_n     (rst_n),
        .sample_en (sample_en),
        .wr_en     (wr_en),
        .wr_data   (wr_data),
        .busy_o    (tx_busy),
        .low_o     (tx_low),
        .done_o    (tx_done_irq)
    );

    card_uart_rx #(.DATA_W(DATA_W), .OVS(OVS)) u_rx (
        .clk       (clk),
        .rst_n     (rst_n),
        .sample_en (sample_en),
        .line_i    (line_i),
        .block_i   (tx_busy | err_drive),
        .line_s_o  (line_level),
        .valid_o   (rx_valid),
        .data_o    (rx_data),
        .par_ok_o  (rx_par_ok)
    );

    card_uart_hold #(.DATA_W(DATA_W)) u_hold (
        .clk         (clk),
        .rst_n       (rst_n),
        .rx_valid    (rx_valid),
        .rx_data     (rx_data),
        .rx_par_ok   (rx_par_ok),
        .rd_en       (rd_en),
        .err_en      (err_sig_en),
        .data_o      (rd_data),
        .full_o      (rx_full),
        .par_err_o   (parity_err),
        .ovr_o       (overrun),
        .err_drive_o (err_drive),
        .irq_o       (rx_irq)
    );

    assign line_drive = tx_low | (err_drive & err_sig_en);

    AST_NO_DRIVE_WHEN_OFF: assert property (@(posedge clk) disable iff (!rst_n)
        (!err_sig_en && !tx_busy) |-> !line_drive)
        else $error("wire driven with signaling off");  // R8
    AST_ERR_ONLY_ON_PARITY: assert property (@(posedge clk) disable iff (!rst_n)
        (line_drive && !tx_busy) |-> parity_err)
        else $error("idle drive without parity error");  // R7

endmodule

// File: tb/card_uart_test.sv
module card_uart_test;
    localparam int CLK_T  = 10;
    localparam int OVS    = 16;
    localparam int DATA_W = 8;
    localparam int NVEC   = 6;
    // vector: {data, bad parity, err_sig_en}
    localparam logic [9:0] VEC [NVEC] = '{
        {8'hA5, 1'b0, 1'b1}, {8'h5A, 1'b1, 1'b1}, {8'h00, 1'b1, 1'b0},
        {8'hFF, 1'b0, 1'b0}, {8'h81, 1'b1, 1'b1}, {8'h7E, 1'b0, 1'b1}
    };

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic sample_en = 1'b1;
    logic drv_low = 1'b0;
    logic line;
    logic line_drive, wr_en = 1'b0, rd_en = 1'b0, err_sig_en = 1'b0;
    logic [DATA_W-1:0] wr_data = '0, rd_data;
    logic tx_busy, tx_done_irq, rx_irq, rx_full, parity_err, overrun, line_level;
    int checks = 0, fails = 0, irq_cnt = 0, cycles = 0;

    assign line = ~(line_drive | drv_low);

    always #(CLK_T / 2) clk = ~clk;

    card_uart #(.DATA_W(DATA_W), .OVS(OVS)) uut (
        .clk(clk), .rst_n(rst_n), .sample_en(sample_en), .line_i(line),
        .line_drive(line_drive), .wr_en(wr_en), .wr_data(wr_data),
        .rd_en(rd_en), .rd_data(rd_data), .err_sig_en(err_sig_en),
        .tx_busy(tx_busy), .tx_done_irq(tx_done_irq), .rx_irq(rx_irq),
        .rx_full(rx_full), .parity_err(parity_err), .overrun(overrun),
        .line_level(line_level)
    );

    always @(posedge clk) begin
        if (rx_irq) irq_cnt <= irq_cnt + 1;
        cycles <= cycles + 1;
        if (cycles > 150000) begin
            fails = fails + 1;
            checks = checks + 1;
            $display("FAIL watchdog: act %0d exp 0", cycles);
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: act %0h exp %0h", req, act, exp);
        end
    endtask

    task automatic send_rx(input logic [7:0] d, input bit bad);
        logic [10:0] fr;
        fr = {1'b1, (^d) ^ bad, d, 1'b0};
        for (int b = 0; b < 11; b++) begin
            drv_low = ~fr[b];
            repeat (OVS) @(negedge clk);
        end
        drv_low = 1'b0;
        repeat (4) @(negedge clk);
    endtask

    task automatic host_read();
        rd_en = 1'b1;
        @(negedge clk);
        rd_en = 1'b0;
    endtask

    task automatic host_write(input logic [7:0] d);
        wr_data = d;
        wr_en = 1'b1;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic run_tx(input logic [7:0] d, input bit far_err);
        logic [10:0] fr;
        int first_done;
        int irq0;
        fr = {1'b1, ^d, d, 1'b0};
        first_done = -1;
        irq0 = irq_cnt;
        host_write(d);
        for (int k = 0; k < 200; k++) begin
            if (k == 50) begin wr_data = 8'hFF; wr_en = 1'b1; end
            if (k == 51) wr_en = 1'b0;
            if (far_err && k == 168) drv_low = 1'b1;
            if (far_err && k == 180) drv_low = 1'b0;
            if (k < 176 && (k % OVS) == OVS / 2)
                check(line_drive == ~fr[k / OVS], "R2 tx bit", line_drive, ~fr[k / OVS]);
            if (tx_done_irq && first_done < 0) begin
                first_done = k;
                if (far_err) check(line_level == 1'b0, "R12 far-end low at done", line_level, 0);
            end
            if (k == 177) begin
                check(tx_done_irq == 1'b0, "R3 done one cycle", tx_done_irq, 0);
                check(tx_busy == 1'b0, "R4 no second frame", tx_busy, 0);
            end
            @(negedge clk);
        end
        check(first_done == 176, "R3 done timing", first_done, 176);
        check(rx_full == 1'b0 && irq_cnt == irq0, "R11 echo ignored", rx_full, 0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        check(line_drive == 0 && tx_busy == 0 && rx_full == 0, "R1 reset outputs", line_drive, 0);
        rst_n = 1'b1;
        @(negedge clk);
        check(!parity_err && !overrun && !tx_done_irq && !rx_irq, "R1 reset flags", parity_err, 0);
        check(line_level == 1'b1, "R12 idle level", line_level, 1);

        for (int v = 0; v < NVEC; v++) begin
            logic [7:0] d;
            bit bad, en;
            int irq0;
            d = VEC[v][9:2];
            bad = VEC[v][1];
            en = VEC[v][0];
            err_sig_en = en;
            irq0 = irq_cnt;
            send_rx(d, bad);
            check(rd_data == d, "R5 rx data", rd_data, d);
            check(rx_full == 1'b1 && irq_cnt == irq0 + 1, "R5 rx full/irq", rx_full, 1);
            check(parity_err == bad, "R6 parity flag", parity_err, bad);
            check(line_drive == (bad & en), en ? "R7 error drive" : "R8 no drive", line_drive, bad & en);
            check(line_level == ~(bad & en), "R12 line level", line_level, ~(bad & en));
            host_read();
            check(!line_drive && !rx_full && !parity_err, "R9 read clears", {line_drive, rx_full, parity_err}, 0);
            repeat (20) @(negedge clk);
        end

        // error drive holds until read
        err_sig_en = 1'b1;
        send_rx(8'h3C, 1'b1);
        repeat (100) @(negedge clk);
        check(line_drive == 1'b1 && rx_full == 1'b1, "R7 held until read", line_drive, 1);
        host_read();
        check(line_drive == 1'b0 && parity_err == 1'b0, "R9 release on read", line_drive, 0);
        repeat (20) @(negedge clk);
        check(rx_full == 1'b0, "R9 no false start after release", rx_full, 0);

        // overrun
        send_rx(8'h11, 1'b0);
        send_rx(8'h22, 1'b0);
        check(rd_data == 8'h11, "R10 old data kept", rd_data, 8'h11);
        check(overrun == 1'b1, "R10 overrun set", overrun, 1);
        host_read();
        check(overrun == 1'b0 && rx_full == 1'b0, "R9 overrun cleared", overrun, 0);
        repeat (20) @(negedge clk);

        // transmit, busy write ignored, echo ignored
        run_tx(8'h3C, 1'b0);
        run_tx(8'hC1, 1'b1);
        repeat (40) @(negedge clk);
        check(rx_full == 1'b0, "R11 far-end glitch rejected", rx_full, 0);

        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule